// File: doc/BRIEF.md
# Master-Slave Mailbox with Wait Handshake

This block is a byte-wide mailbox that links a local slave processor to a bus master. The local side has a data port, a command port and a status byte. The master side has a matching data port. Each direction has its own holding register: a local data write leaves a byte for the master, and a local data read returns the last byte the master wrote.

With wait protocol on, every local data-port access stalls the local processor until the master performs the complementary access. A local write waits for a master read, and a local read waits for a master write. This couples the two processors byte by byte for block transfers. A sticky sync-error flag records any master data access made outside such a rendezvous. One command write also raises a service request to the master, clears the error flags, passes three free command bits to the master and switches the boot ROM. Single-cycle pulses mark each master read and each master write, for use as interrupt sources.

Top module: `mbox_rendezvous`

## Requirements
- R1: After reset `loc_wait` is 0, wait protocol is off, the service request, sync-error and parity-error flags are 0, `rom_en` is 1 and `mst_cmd` is 0.
- R2: With wait protocol off, a local data write of byte B makes `mst_rdata` equal B one cycle later, and a master write of B makes `loc_rdata` equal B one cycle later. Neither raises `loc_wait`, and neither sets the sync-error flag.
- R3: A command write takes bits 7:5 to `mst_cmd` and bit 0 to `rom_en` (1 = ROM on). Bit 4 = 0 turns wait protocol on and bit 4 = 1 turns it off. The new values are visible from the next cycle.
- R4: `loc_stat` is {`dsr_in`[3:0], service request, sync error, parity error, `sense_in`} from bit 7 down to bit 0. `sense_in` = 0 means the switch is closed.
- R5: With wait protocol on, a local data write raises `loc_wait` in the next cycle. It stays high until a master read strobe and is low in the cycle after that strobe. The master read returns the byte that was written.
- R6: With wait protocol on, a local data read raises `loc_wait` in the next cycle. It stays high until a master write strobe and is low in the cycle after that strobe. At that point `loc_rdata` holds the master's byte.
- R7: With wait protocol on, a master data access that does not complete a pending rendezvous sets sync error (status bit 2). This includes an access while nothing is pending and an access in the wrong direction, which does not release the stall. The flag is sticky. A command write with bit 2 = 1 clears it, and a new event in the same cycle wins over the clear.
- R8: A pulse on `par_err_in` sets the parity-error flag (status bit 1). The flag is sticky. A command write with bit 1 = 1 clears it, and a new error in the same cycle wins over the clear.
- R9: A command write with bit 3 = 1 sets the service request (status bit 3 and `svc_req`). Bit 3 = 0 leaves it unchanged. `mst_svc_clr` clears it, and a set in the same cycle wins over the clear.
- R10: `mst_rd_pulse` and `mst_wr_pulse` are high for exactly the cycle after a master read or write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| loc_data_wr | input | 1 | Local data-port write strobe |
| loc_data_rd | input | 1 | Local data-port read strobe |
| loc_wdata | input | 8 | Local write byte (data or command) |
| loc_rdata | output | 8 | Byte last written by the master |
| loc_wait | output | 1 | Stall request to the local processor |
| loc_cmd_wr | input | 1 | Local command-port write strobe |
| loc_stat | output | 8 | Status byte for the local processor |
| mst_wr_stb | input | 1 | Master data-port write strobe (address matched) |
| mst_rd_stb | input | 1 | Master data-port read strobe (address matched) |
| mst_wdata | input | 8 | Master write byte |
| mst_rdata | output | 8 | Byte last written by the local side |
| mst_svc_clr | input | 1 | Master clears the service request |
| mst_cmd | output | 3 | Free command bits to the master |
| svc_req | output | 1 | Service request to the master |
| rom_en | output | 1 | Boot ROM enable |
| par_err_in | input | 1 | Parity-error event pulse |
| dsr_in | input | 4 | Data-set-ready lines of four serial channels |
| sense_in | input | 1 | Sense switch, 0 = closed |
| mst_rd_pulse | output | 1 | One-cycle pulse after a master read |
| mst_wr_pulse | output | 1 | One-cycle pulse after a master write |

## Verification
The properties assume that the local processor issues no new data-port strobe while `loc_wait` is high, because it is stalled. They also assume that strobes last one cycle and that wait protocol is not switched while a rendezvous is pending. The stimulus keeps to these rules. Each strobe is held for one cycle. A new local access starts only after the release has been observed. The mode changes only when nothing is pending. Wrong-direction master accesses are applied on purpose, because they are legal master behaviour that the design has to flag.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    localparam int MB_DW     = 8;
    localparam int MB_DSR_N  = 4;
    localparam int MB_CMDF_W = 3;

    typedef enum logic [1:0] {
        PEND_NONE = 2'd0,
        PEND_WR   = 2'd1,
        PEND_RD   = 2'd2
    } pend_e;

    typedef struct packed {
        logic [MB_CMDF_W-1:0] free_bits;
        logic                 no_wait;
        logic                 svc_set;
        logic                 clr_sync;
        logic                 clr_par;
        logic                 rom_on;
    } cmd_word_t;

    function automatic cmd_word_t decode_cmd(input logic [MB_DW-1:0] d);
        cmd_word_t c;
        c = cmd_word_t'(d);
        return c;
    endfunction

    function automatic logic [MB_DW-1:0] pack_status(
        input logic [MB_DSR_N-1:0] dsr,
        input logic svc, input logic sync_e, input logic par_e, input logic sense);
        return {dsr, svc, sync_e, par_e, sense};
    endfunction
endpackage

// File: rtl/mbox_handshake.sv
module mbox_handshake
    import mbox_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wait_mode,
    input  logic             loc_wr,
    input  logic             loc_rd,
    input  logic [MB_DW-1:0] loc_wdata,
    input  logic             mst_wr,
    input  logic             mst_rd,
    input  logic [MB_DW-1:0] mst_wdata,
    output logic [MB_DW-1:0] to_mst,
    output logic [MB_DW-1:0] from_mst,
    output logic             loc_wait,
    output logic             sync_evt,
    output logic             rd_pulse,
    output logic             wr_pulse
);
    pend_e pend_q, pend_d;
    logic  done_wr, done_rd;

    always_comb begin
        done_wr  = (pend_q == PEND_WR) && mst_rd;
        done_rd  = (pend_q == PEND_RD) && mst_wr;
        sync_evt = wait_mode && (mst_rd || mst_wr) && !done_wr && !done_rd;
        pend_d   = pend_q;
        unique case (pend_q)
            PEND_NONE: begin
                if (wait_mode && loc_wr)      pend_d = PEND_WR;
                else if (wait_mode && loc_rd) pend_d = PEND_RD;
            end
            PEND_WR: if (done_wr) pend_d = PEND_NONE;
            PEND_RD: if (done_rd) pend_d = PEND_NONE;
            default: pend_d = PEND_NONE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q   <= PEND_NONE;
            to_mst   <= '0;
            from_mst <= '0;
            rd_pulse <= 1'b0;
            wr_pulse <= 1'b0;
        end else begin
            pend_q   <= pend_d;
            rd_pulse <= mst_rd;
            wr_pulse <= mst_wr;
            if (loc_wr) to_mst   <= loc_wdata;
            if (mst_wr) from_mst <= mst_wdata;
        end
    end

    assign loc_wait = (pend_q != PEND_NONE);
endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
    import mbox_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cmd_wr,
    input  logic [MB_DW-1:0]     cmd_data,
    input  logic                 sync_evt,
    input  logic                 par_evt,
    input  logic                 svc_clr,
    input  logic [MB_DSR_N-1:0]  dsr,
    input  logic                 sense,
    output logic                 wait_mode,
    output logic                 rom_en,
    output logic [MB_CMDF_W-1:0] cmd_bits,
    output logic                 svc,
    output logic [MB_DW-1:0]     status
);
    cmd_word_t cw;
    logic      sync_q, par_q;

    always_comb cw = decode_cmd(cmd_data);

    always_ff @(posedge clk) begin
        if (rst) begin
            wait_mode <= 1'b0;
            rom_en    <= 1'b1;
            cmd_bits  <= '0;
            svc       <= 1'b0;
            sync_q    <= 1'b0;
            par_q     <= 1'b0;
        end else begin
            if (cmd_wr) begin
                wait_mode <= !cw.no_wait;
                rom_en    <= cw.rom_on;
                cmd_bits  <= cw.free_bits;
            end
            svc    <= (svc    && !svc_clr)                 || (cmd_wr && cw.svc_set);
            sync_q <= (sync_q && !(cmd_wr && cw.clr_sync)) || sync_evt;
            par_q  <= (par_q  && !(cmd_wr && cw.clr_par))  || par_evt;
        end
    end

    assign status = pack_status(dsr, svc, sync_q, par_q, sense);
endmodule

// File: rtl/mbox_rendezvous.sv
module mbox_rendezvous
    import mbox_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 loc_data_wr,
    input  logic                 loc_data_rd,
    input  logic [MB_DW-1:0]     loc_wdata,
    output logic [MB_DW-1:0]     loc_rdata,
    output logic                 loc_wait,
    input  logic                 loc_cmd_wr,
    output logic [MB_DW-1:0]     loc_stat,
    input  logic                 mst_wr_stb,
    input  logic                 mst_rd_stb,
    input  logic [MB_DW-1:0]     mst_wdata,
    output logic [MB_DW-1:0]     mst_rdata,
    input  logic                 mst_svc_clr,
    output logic [MB_CMDF_W-1:0] mst_cmd,
    output logic                 svc_req,
    output logic                 rom_en,
    input  logic                 par_err_in,
    input  logic [MB_DSR_N-1:0]  dsr_in,
    input  logic                 sense_in,
    output logic                 mst_rd_pulse,
    output logic                 mst_wr_pulse
);
    logic wait_mode;
    logic sync_evt;

    mbox_handshake u_hs (
        .clk       (clk),
        .rst       (rst),
        .wait_mode (wait_mode),
        .loc_wr    (loc_data_wr),
        .loc_rd    (loc_data_rd),
        .loc_wdata (loc_wdata),
        .mst_wr    (mst_wr_stb),
        .mst_rd    (mst_rd_stb),
        .mst_wdata (mst_wdata),
        .to_mst    (mst_rdata),
        .from_mst  (loc_rdata),
        .loc_wait  (loc_wait),
        .sync_evt  (sync_evt),
        .rd_pulse  (mst_rd_pulse),
        .wr_pulse  (mst_wr_pulse)
    );

    mbox_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cmd_wr    (loc_cmd_wr),
        .cmd_data  (loc_wdata),
        .sync_evt  (sync_evt),
        .par_evt   (par_err_in),
        .svc_clr   (mst_svc_clr),
        .dsr       (dsr_in),
        .sense     (sense_in),
        .wait_mode (wait_mode),
        .rom_en    (rom_en),
        .cmd_bits  (mst_cmd),
        .svc       (svc_req),
        .status    (loc_stat)
    );
endmodule

// File: rtl/mbox_rendezvous_chk.sv
module mbox_rendezvous_chk (
    input logic       clk,
    input logic       rst,
    input logic       loc_data_wr,
    input logic       loc_data_rd,
    input logic [7:0] loc_wdata,
    input logic [7:0] loc_rdata,
    input logic       loc_wait,
    input logic       loc_cmd_wr,
    input logic [7:0] loc_stat,
    input logic       mst_wr_stb,
    input logic       mst_rd_stb,
    input logic [7:0] mst_wdata,
    input logic [7:0] mst_rdata,
    input logic       svc_req,
    input logic       rom_en,
    input logic       par_err_in,
    input logic       mst_rd_pulse
);
    assert_wait_holds_R5: assert property (@(posedge clk) disable iff (rst)
        (loc_wait && !mst_rd_stb && !mst_wr_stb) |=> loc_wait);

    assert_no_spurious_wait_R1: assert property (@(posedge clk) disable iff (rst)
        (!loc_wait && !loc_data_wr && !loc_data_rd) |=> !loc_wait);

    assert_mst_byte_lands_R6: assert property (@(posedge clk) disable iff (rst)
        mst_wr_stb |=> (loc_rdata == $past(mst_wdata)));

    assert_loc_byte_lands_R2: assert property (@(posedge clk) disable iff (rst)
        loc_data_wr |=> (mst_rdata == $past(loc_wdata)));

    assert_sync_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (loc_stat[2] && !(loc_cmd_wr && loc_wdata[2])) |=> loc_stat[2]);

    assert_parity_set_R8: assert property (@(posedge clk) disable iff (rst)
        par_err_in |=> loc_stat[1]);

    assert_svc_set_R9: assert property (@(posedge clk) disable iff (rst)
        (loc_cmd_wr && loc_wdata[3]) |=> svc_req);

    assert_rom_follows_R3: assert property (@(posedge clk) disable iff (rst)
        loc_cmd_wr |=> (rom_en == $past(loc_wdata[0])));

    assert_rd_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        mst_rd_stb |=> mst_rd_pulse);
endmodule

bind mbox_rendezvous mbox_rendezvous_chk chk_i (
    .clk          (clk),
    .rst          (rst),
    .loc_data_wr  (loc_data_wr),
    .loc_data_rd  (loc_data_rd),
    .loc_wdata    (loc_wdata),
    .loc_rdata    (loc_rdata),
    .loc_wait     (loc_wait),
    .loc_cmd_wr   (loc_cmd_wr),
    .loc_stat     (loc_stat),
    .mst_wr_stb   (mst_wr_stb),
    .mst_rd_stb   (mst_rd_stb),
    .mst_wdata    (mst_wdata),
    .mst_rdata    (mst_rdata),
    .svc_req      (svc_req),
    .rom_en       (rom_en),
    .par_err_in   (par_err_in),
    .mst_rd_pulse (mst_rd_pulse)
);

// File: tb/mbox_rendezvous_tb.sv
`timescale 1ns/1ps
module mbox_rendezvous_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       loc_data_wr, loc_data_rd, loc_cmd_wr;
    logic [7:0] loc_wdata, loc_rdata, loc_stat;
    logic       loc_wait;
    logic       mst_wr_stb, mst_rd_stb, mst_svc_clr;
    logic [7:0] mst_wdata, mst_rdata;
    logic [2:0] mst_cmd;
    logic       svc_req, rom_en, par_err_in, sense_in;
    logic [3:0] dsr_in;
    logic       mst_rd_pulse, mst_wr_pulse;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    mbox_rendezvous dut_i (
        .clk(clk), .rst(rst),
        .loc_data_wr(loc_data_wr), .loc_data_rd(loc_data_rd),
        .loc_wdata(loc_wdata), .loc_rdata(loc_rdata), .loc_wait(loc_wait),
        .loc_cmd_wr(loc_cmd_wr), .loc_stat(loc_stat),
        .mst_wr_stb(mst_wr_stb), .mst_rd_stb(mst_rd_stb),
        .mst_wdata(mst_wdata), .mst_rdata(mst_rdata),
        .mst_svc_clr(mst_svc_clr), .mst_cmd(mst_cmd),
        .svc_req(svc_req), .rom_en(rom_en), .par_err_in(par_err_in),
        .dsr_in(dsr_in), .sense_in(sense_in),
        .mst_rd_pulse(mst_rd_pulse), .mst_wr_pulse(mst_wr_pulse)
    );

    // Plain-mode data vectors: {master_side, byte}
    localparam logic [8:0] DATA_VEC [6] = '{
        {1'b0, 8'h3C}, {1'b1, 8'h5A}, {1'b0, 8'hFF},
        {1'b1, 8'h00}, {1'b0, 8'h81}, {1'b1, 8'hA7}
    };
    // Command vectors with bit 4 = 1: {cmd, exp mst_cmd, exp rom_en, exp svc}
    localparam logic [12:0] CMD_VEC [4] = '{
        {8'hF8, 3'd7, 1'b0, 1'b1},
        {8'h31, 3'd1, 1'b1, 1'b1},
        {8'h50, 3'd2, 1'b0, 1'b1},
        {8'hB1, 3'd5, 1'b1, 1'b1}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic idle();
        loc_data_wr = 0; loc_data_rd = 0; loc_cmd_wr = 0;
        mst_wr_stb = 0; mst_rd_stb = 0; mst_svc_clr = 0; par_err_in = 0;
    endtask

    task automatic cmd(input logic [7:0] v);
        loc_cmd_wr = 1; loc_wdata = v; step(); idle();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle();
        loc_wdata = 0; mst_wdata = 0; dsr_in = 4'b1010; sense_in = 1'b1;
        rst = 1;
        repeat (3) step();
        rst = 0;
        step();

        // Reset state
        chk("R1 loc_wait", {7'd0, loc_wait}, 8'd0);
        chk("R1 rom_en", {7'd0, rom_en}, 8'd1);
        chk("R1 mst_cmd", {5'd0, mst_cmd}, 8'd0);
        chk("R4 R1 status", loc_stat, 8'hA1);

        // Plain mode data vectors
        foreach (DATA_VEC[i]) begin
            if (DATA_VEC[i][8]) begin
                mst_wr_stb = 1; mst_wdata = DATA_VEC[i][7:0];
            end else begin
                loc_data_wr = 1; loc_wdata = DATA_VEC[i][7:0];
            end
            step(); idle();
            if (DATA_VEC[i][8]) chk("R2 loc_rdata", loc_rdata, DATA_VEC[i][7:0]);
            else                chk("R2 mst_rdata", mst_rdata, DATA_VEC[i][7:0]);
            chk("R2 no wait", {7'd0, loc_wait}, 8'd0);
        end
        mst_rd_stb = 1; step(); idle();
        chk("R2 no sync in plain mode", {7'd0, loc_stat[2]}, 8'd0);

        // Command vectors
        foreach (CMD_VEC[i]) begin
            cmd(CMD_VEC[i][12:5]);
            chk("R3 mst_cmd", {5'd0, mst_cmd}, {5'd0, CMD_VEC[i][4:2]});
            chk("R3 rom_en", {7'd0, rom_en}, {7'd0, CMD_VEC[i][1]});
            chk("R9 svc", {7'd0, svc_req}, {7'd0, CMD_VEC[i][0]});
        end
        chk("R9 svc status bit", {7'd0, loc_stat[3]}, 8'd1);
        mst_svc_clr = 1; step(); idle();
        chk("R9 master clears svc", {7'd0, svc_req}, 8'd0);
        mst_svc_clr = 1; loc_cmd_wr = 1; loc_wdata = 8'h19; step(); idle();
        chk("R9 set wins over clear", {7'd0, svc_req}, 8'd1);
        mst_svc_clr = 1; step(); idle();

        // Status lines
        dsr_in = 4'b0101; sense_in = 1'b0;
        #1;
        chk("R4 dsr and sense", {loc_stat[7:4], 3'd0, loc_stat[0]}, 8'h50);

        // Parity
        par_err_in = 1; step(); idle();
        chk("R8 parity set", {7'd0, loc_stat[1]}, 8'd1);
        step();
        chk("R8 parity sticky", {7'd0, loc_stat[1]}, 8'd1);
        cmd(8'h13);
        chk("R8 parity cleared", {7'd0, loc_stat[1]}, 8'd0);
        par_err_in = 1; loc_cmd_wr = 1; loc_wdata = 8'h13; step(); idle();
        chk("R8 set wins over clear", {7'd0, loc_stat[1]}, 8'd1);
        cmd(8'h13);

        // Enter wait mode
        cmd(8'h01);
        loc_data_wr = 1; loc_wdata = 8'hC3; step(); idle();
        chk("R5 wait raised", {7'd0, loc_wait}, 8'd1);
        repeat (3) step();
        chk("R5 wait held", {7'd0, loc_wait}, 8'd1);
        mst_rd_stb = 1; #1;
        chk("R5 master reads byte", mst_rdata, 8'hC3);
        step(); idle();
        chk("R5 wait released", {7'd0, loc_wait}, 8'd0);
        chk("R10 read pulse", {7'd0, mst_rd_pulse}, 8'd1);
        chk("R7 no sync on rendezvous", {7'd0, loc_stat[2]}, 8'd0);
        step();
        chk("R10 read pulse ends", {7'd0, mst_rd_pulse}, 8'd0);

        loc_data_rd = 1; step(); idle();
        chk("R6 wait raised", {7'd0, loc_wait}, 8'd1);
        step();
        mst_wr_stb = 1; mst_wdata = 8'h96; step(); idle();
        chk("R6 wait released", {7'd0, loc_wait}, 8'd0);
        chk("R6 byte delivered", loc_rdata, 8'h96);
        chk("R10 write pulse", {7'd0, mst_wr_pulse}, 8'd1);
        chk("R6 no sync on rendezvous", {7'd0, loc_stat[2]}, 8'd0);

        // Sync errors
        mst_rd_stb = 1; step(); idle();
        chk("R7 sync on idle access", {7'd0, loc_stat[2]}, 8'd1);
        repeat (2) step();
        chk("R7 sync sticky", {7'd0, loc_stat[2]}, 8'd1);
        cmd(8'h05);
        chk("R7 sync cleared", {7'd0, loc_stat[2]}, 8'd0);
        loc_data_wr = 1; loc_wdata = 8'h11; step(); idle();
        mst_wr_stb = 1; mst_wdata = 8'h22; step(); idle();
        chk("R7 wrong direction keeps wait", {7'd0, loc_wait}, 8'd1);
        chk("R7 wrong direction sets sync", {7'd0, loc_stat[2]}, 8'd1);
        mst_rd_stb = 1; step(); idle();
        chk("R5 release after wrong dir", {7'd0, loc_wait}, 8'd0);
        cmd(8'h05);
        mst_rd_stb = 1; loc_cmd_wr = 1; loc_wdata = 8'h05; step(); idle();
        chk("R7 event wins over clear", {7'd0, loc_stat[2]}, 8'd1);

        // Back to plain mode
        cmd(8'h15);
        loc_data_rd = 1; step(); idle();
        chk("R3 wait mode off", {7'd0, loc_wait}, 8'd0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule